// File: doc/BRIEF.md
# Resolver angle tracking loop

This block turns a stream of demodulated resolver samples into a live shaft angle. On each pulse of a steady sample strobe it receives one signed sample of the sine channel and one of the cosine channel. It holds its own estimate of the angle in a 16-bit up/down counter and looks up the sine and cosine of that estimate. From these it forms an error term proportional to the sine of the difference between the true and the estimated angle.

The error drives a type 2 loop. A saturating integrator plus a proportional path set a signed rate. A phase accumulator turns the rate into single up or down pulses for the counter. The counter settles where the error is nulled and then follows the shaft with no convert command. A moving shaft is followed with no steady lag.

The angle word and the integrator value, which serves as the velocity word, are both available as outputs at all times. Reading them has no effect on the loop.

Top module: `angle_tracker`

## Requirements
- R1: While reset is held, and after its release until the first sample strobe, `angle_o` reads 0 and `vel_o` reads 0. `angle_o` is unsigned binary in which one LSB is 1/65536 of a turn.
- R2: The inputs are two's complement. For a shaft angle θ (in LSB), the inputs are `sin_smp` = A·sin(2πθ/65536) and `cos_smp` = A·cos(2πθ/65536), with A near 2000. For a static θ in any quadrant, `angle_o` settles to within ±128 LSB of θ (circular distance).
- R3: `angle_o` changes by 0, +1 or −1 per clock, never more.
- R4: The counter wraps modulo 65536 and starts toward the nearer side. From 0 with θ = 16384, its first change gives 1. From 0 with θ = 60000, its first change gives 65535.
- R5: When θ advances by a constant amount per strobe, `angle_o` tracks it within ±128 LSB. `vel_o` then settles to v·2^20 within ±25%, where v is the rate in LSB per clock, with the sign of the direction of motion.
- R6: Between strobes the integrator and error registers hold. With the strobe held low from reset, `angle_o` and `vel_o` stay 0 whatever the sample inputs are.
- R7: The integrator saturates symmetrically at ±(2^20−1) instead of wrapping. During a long slew toward a distant angle, `vel_o` reads exactly 1048575.
- R8: During a large slew the counter moves at most one step per clock. It moves on at least 999 of any 1000 clocks in that state.
- R9: Asserting reset in the middle of tracking returns `angle_o` and `vel_o` to 0 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_stb | input | 1 | One-cycle strobe marking a new sample pair |
| sin_smp | input | 12 | Signed sine channel sample |
| cos_smp | input | 12 | Signed cosine channel sample |
| angle_o | output | 16 | Tracked angle, natural binary |
| vel_o | output | 21 | Signed integrator value (velocity) |

## Verification
The checker watches every cycle for the following:
- the counter moves by at most one LSB;
- each up or down pulse from the oscillator lands as exactly one matching step;
- no step occurs without a pulse;
- the velocity word holds between strobes;
- the saturated integrator never reaches the asymmetric negative code.

Other behaviours only show up in the bench's scenarios, because they depend on the whole loop settling. These are convergence accuracy around all quadrants and across the wrap point, the direction of the first step, zero-lag tracking of a ramp with its velocity scale, and saturation during a slew.

// File: rtl/trk_pkg.sv
package trk_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_e;
endpackage

// File: rtl/trk_sincos.sv
// Quarter-wave sine/cosine of the current estimate with quadrant folding.
module trk_sincos #(
  parameter int AMP_W    = 12,
  parameter int LUT_BITS = 9
) (
  input  logic [LUT_BITS+1:0]      phase_i,
  output logic signed [AMP_W-1:0]  sin_o,
  output logic signed [AMP_W-1:0]  cos_o
);
  localparam int  QN    = 1 << LUT_BITS;
  localparam int  MAG_W = AMP_W - 1;
  localparam real AMP   = real'((1 << (AMP_W - 1)) - 1);
  localparam real HALF_PI = 1.5707963267948966;

  logic [MAG_W-1:0] qtab [QN];

  // entries sampled at bin centres so both folds are symmetric
  generate
    for (genvar k = 0; k < QN; k++) begin : g_tab
      localparam real ARG = (real'(k) + 0.5) * HALF_PI / real'(QN);
      localparam int  VAL = $rtoi(AMP * $sin(ARG) + 0.5);
      assign qtab[k] = VAL[MAG_W-1:0];
    end
  endgenerate

  logic [1:0]              quad;
  logic [LUT_BITS-1:0]     k_fwd;
  logic [LUT_BITS-1:0]     k_rev;
  logic signed [AMP_W-1:0] mag_a;
  logic signed [AMP_W-1:0] mag_b;

  always_comb begin
    quad  = phase_i[LUT_BITS+1:LUT_BITS];
    k_fwd = phase_i[LUT_BITS-1:0];
    k_rev = ~k_fwd;
    mag_a = $signed({1'b0, qtab[k_fwd]});
    mag_b = $signed({1'b0, qtab[k_rev]});
    unique case (quad)
      2'd0:    begin sin_o =  mag_a; cos_o =  mag_b; end
      2'd1:    begin sin_o =  mag_b; cos_o = -mag_a; end
      2'd2:    begin sin_o = -mag_a; cos_o = -mag_b; end
      default: begin sin_o = -mag_b; cos_o =  mag_a; end
    endcase
  end
endmodule

// File: rtl/trk_loop_filter.sv
// Error former, saturating integrator and proportional path.
module trk_loop_filter #(
  parameter int IN_W      = 12,
  parameter int AMP_W     = 12,
  parameter int ACC_W     = 16,
  parameter int KP_SHIFT  = 0,
  parameter int KI_SHIFT  = 4,
  parameter int VEL_SHIFT = 4,
  parameter int VEL_W     = 21
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    stb_i,
  input  logic signed [IN_W-1:0]  sin_smp_i,
  input  logic signed [IN_W-1:0]  cos_smp_i,
  input  logic signed [AMP_W-1:0] sin_est_i,
  input  logic signed [AMP_W-1:0] cos_est_i,
  output logic signed [ACC_W:0]   rate_o,
  output logic signed [VEL_W-1:0] vel_o
);
  localparam int ERR_W = IN_W + AMP_W + 1;
  localparam int SUM_W = ((ERR_W > VEL_W) ? ERR_W : VEL_W) + 2;
  localparam int RS_W  = ((ERR_W > ACC_W + 1) ? ERR_W : ACC_W + 1) + 2;
  localparam logic signed [SUM_W-1:0] V_HI = SUM_W'((64'sd1 <<< (VEL_W - 1)) - 64'sd1);
  localparam logic signed [SUM_W-1:0] V_LO = -V_HI;
  localparam logic signed [RS_W-1:0]  R_HI = RS_W'((64'sd1 <<< ACC_W) - 64'sd1);
  localparam logic signed [RS_W-1:0]  R_LO = -R_HI;

  logic signed [ERR_W-1:0] err_c, err_q, err_n;
  logic signed [VEL_W-1:0] vel_q, vel_n;
  logic signed [SUM_W-1:0] vel_sum;
  logic signed [RS_W-1:0]  rate_sum;

  always_comb begin
    err_c = (ERR_W'(sin_smp_i) * ERR_W'(cos_est_i)) -
            (ERR_W'(cos_smp_i) * ERR_W'(sin_est_i));
    vel_sum = SUM_W'(vel_q) + SUM_W'(err_c >>> KI_SHIFT);
    err_n = err_q;
    vel_n = vel_q;
    if (stb_i) begin
      err_n = err_c;
      if (vel_sum > V_HI)      vel_n = V_HI[VEL_W-1:0];
      else if (vel_sum < V_LO) vel_n = V_LO[VEL_W-1:0];
      else                     vel_n = vel_sum[VEL_W-1:0];
    end
    rate_sum = RS_W'(vel_q >>> VEL_SHIFT) + RS_W'(err_q >>> KP_SHIFT);
    if (rate_sum > R_HI)      rate_o = R_HI[ACC_W:0];
    else if (rate_sum < R_LO) rate_o = R_LO[ACC_W:0];
    else                      rate_o = rate_sum[ACC_W:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0;
      vel_q <= '0;
    end else if (stb_i) begin
      err_q <= err_n;
      vel_q <= vel_n;
    end
  end

  assign vel_o = vel_q;
endmodule

// File: rtl/trk_rate_osc.sv
// Phase accumulator: carry gives an up pulse, borrow a down pulse.
module trk_rate_osc
  import trk_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic signed [ACC_W:0] rate_i,
  output step_e                 step_o
);
  logic [ACC_W-1:0]          acc_q, acc_n;
  logic signed [ACC_W+1:0]   acc_sum;

  always_comb begin
    acc_sum = $signed({2'b00, acc_q}) + (ACC_W + 2)'(rate_i);
    acc_n   = acc_sum[ACC_W-1:0];
    if (acc_sum[ACC_W+1])    step_o = STEP_DN;
    else if (acc_sum[ACC_W]) step_o = STEP_UP;
    else                     step_o = STEP_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_n;
  end
endmodule

// File: rtl/trk_updown_ctr.sv
// Angle counter, modulo 2^ANG_W in both directions.
module trk_updown_ctr
  import trk_pkg::*;
#(
  parameter int ANG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  step_e            step_i,
  output logic [ANG_W-1:0] angle_o
);
  logic [ANG_W-1:0] cnt_q, cnt_n;
  logic             cnt_en;

  always_comb begin
    cnt_en = (step_i != STEP_NONE);
    cnt_n  = (step_i == STEP_UP) ? cnt_q + 1'b1 : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign angle_o = cnt_q;
endmodule

// File: rtl/angle_tracker.sv
module angle_tracker
  import trk_pkg::*;
#(
  parameter int ANG_W     = 16,
  parameter int IN_W      = 12,
  parameter int AMP_W     = 12,
  parameter int LUT_BITS  = 9,
  parameter int ACC_W     = 16,
  parameter int KP_SHIFT  = 0,
  parameter int KI_SHIFT  = 4,
  parameter int VEL_SHIFT = 4,
  localparam int VEL_W    = ACC_W + VEL_SHIFT + 1,
  localparam int IDX_W    = LUT_BITS + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_stb,
  input  logic signed [IN_W-1:0]  sin_smp,
  input  logic signed [IN_W-1:0]  cos_smp,
  output logic [ANG_W-1:0]        angle_o,
  output logic signed [VEL_W-1:0] vel_o
);
  logic [1:0]              rst_sync_q;
  logic                    rst_int_n;
  logic signed [AMP_W-1:0] sin_est, cos_est;
  logic signed [ACC_W:0]   rate_w;
  step_e                   step_w;

  // assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  trk_sincos #(.AMP_W(AMP_W), .LUT_BITS(LUT_BITS)) u_sincos (
    .phase_i (angle_o[ANG_W-1 -: IDX_W]),
    .sin_o   (sin_est),
    .cos_o   (cos_est)
  );

  trk_loop_filter #(
    .IN_W(IN_W), .AMP_W(AMP_W), .ACC_W(ACC_W), .KP_SHIFT(KP_SHIFT),
    .KI_SHIFT(KI_SHIFT), .VEL_SHIFT(VEL_SHIFT), .VEL_W(VEL_W)
  ) u_filter (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .stb_i     (smp_stb),
    .sin_smp_i (sin_smp),
    .cos_smp_i (cos_smp),
    .sin_est_i (sin_est),
    .cos_est_i (cos_est),
    .rate_o    (rate_w),
    .vel_o     (vel_o)
  );

  trk_rate_osc #(.ACC_W(ACC_W)) u_osc (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .rate_i (rate_w),
    .step_o (step_w)
  );

  trk_updown_ctr #(.ANG_W(ANG_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .step_i  (step_w),
    .angle_o (angle_o)
  );
endmodule

// File: rtl/trk_checker.sv
module trk_checker
  import trk_pkg::*;
#(
  parameter int ANG_W = 16,
  parameter int VEL_W = 21
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    stb,
  input logic [ANG_W-1:0]        angle,
  input logic signed [VEL_W-1:0] vel,
  input step_e                   step
);
  localparam logic [VEL_W-1:0] V_MIN = {1'b1, {(VEL_W-1){1'b0}}};

  AST_SINGLE_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    (angle == $past(angle)) || (angle == $past(angle) + 1'b1) || (angle == $past(angle) - 1'b1))
    else $error("angle moved by more than one LSB"); // R3

  AST_UP_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_UP) |=> (angle == $past(angle) + 1'b1))
    else $error("up pulse not applied"); // R4

  AST_DN_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_DN) |=> (angle == $past(angle) - 1'b1))
    else $error("down pulse not applied"); // R4

  AST_NO_STRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_NONE) |=> $stable(angle))
    else $error("angle moved without a pulse"); // R3

  AST_VEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(vel))
    else $error("velocity changed between strobes"); // R6

  AST_VEL_SYMMETRIC: assert property (@(posedge clk) disable iff (!rst_n)
    vel != V_MIN)
    else $error("integrator reached asymmetric code"); // R7
endmodule

bind angle_tracker trk_checker #(.ANG_W(ANG_W), .VEL_W(VEL_W)) u_trk_checker (
  .clk   (clk),
  .rst_n (rst_n),
  .stb   (smp_stb),
  .angle (angle_o),
  .vel   (vel_o),
  .step  (step_w)
);

// File: tb/test_angle_tracker.sv
module test_angle_tracker;
  localparam real TWO_PI = 6.283185307179586;
  localparam real AMPL   = 2000.0;
  localparam int  TOL    = 128;
  localparam int  VSAT   = 1048575;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               smp_stb = 1'b0;
  logic signed [11:0] sin_smp = '0;
  logic signed [11:0] cos_smp = '0;
  logic [15:0]        angle_o;
  logic signed [20:0] vel_o;

  int  n_chk = 0;
  int  n_err = 0;
  int  bad_steps = 0;
  real theta = 0.0;
  real dtheta = 0.0;
  bit  stb_en = 1'b0;

  always #10 clk = ~clk;

  angle_tracker i_angle_tracker (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb),
    .sin_smp(sin_smp), .cos_smp(cos_smp),
    .angle_o(angle_o), .vel_o(vel_o)
  );

  function automatic int rnd(input real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  function automatic int adiff(input logic [15:0] a, input real t);
    logic [15:0] d;
    d = a - 16'(rnd(t) % 65536);
    return int'($signed(d));
  endfunction

  function automatic int iabs(input int x);
    return (x < 0) ? -x : x;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // sample source: every 4th clock a strobe, inputs always follow theta
  initial begin
    int phase_cnt = 0;
    forever begin
      @(negedge clk);
      phase_cnt++;
      if (stb_en && (phase_cnt % 4 == 0)) begin
        theta = theta + dtheta;
        if (theta >= 65536.0) theta = theta - 65536.0;
        if (theta < 0.0)      theta = theta + 65536.0;
        smp_stb = 1'b1;
      end else begin
        smp_stb = 1'b0;
      end
      sin_smp = 12'(rnd(AMPL * $sin(TWO_PI * theta / 65536.0)));
      cos_smp = 12'(rnd(AMPL * $cos(TWO_PI * theta / 65536.0)));
    end
  end

  // R3: single-LSB motion, seen at the ports on every clock
  initial begin
    logic [15:0] prev = '0;
    bit          valid = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst_n) valid = 1'b0;
      else begin
        if (valid && (angle_o != prev) && (angle_o != prev + 16'd1) && (angle_o != prev - 16'd1))
          bad_steps++;
        prev  = angle_o;
        valid = 1'b1;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int a0;
    // R1: reset state
    stb_en = 1'b0; dtheta = 0.0; theta = 16384.0;
    rst_n = 1'b0;
    ticks(4);
    check(angle_o == 16'd0, "R1 angle in reset", angle_o, 0);
    check(vel_o == 21'sd0, "R1 vel in reset", vel_o, 0);
    rst_n = 1'b1;

    // R6: strobe held low, inputs present, nothing moves
    ticks(2000);
    check(angle_o == 16'd0, "R6 angle without strobe", angle_o, 0);
    check(vel_o == 21'sd0, "R6 vel without strobe", vel_o, 0);

    // R4: first step toward the nearer side (upward)
    stb_en = 1'b1;
    for (int i = 0; i < 2000 && angle_o == 16'd0; i++) @(negedge clk);
    check(angle_o == 16'd1, "R4 first step up", angle_o, 1);

    // R7: saturation during a long slew
    ticks(3000);
    check(vel_o == 21'(VSAT), "R7 saturated vel", vel_o, VSAT);

    // R8: slew rate of one step per clock
    a0 = int'(angle_o);
    ticks(1000);
    check((int'(angle_o) - a0 >= 999) && (int'(angle_o) - a0 <= 1000),
          "R8 slew over 1000 clocks", int'(angle_o) - a0, 1000);

    // R9: reset mid-run
    rst_n = 1'b0;
    stb_en = 1'b0;
    ticks(2);
    check(angle_o == 16'd0, "R9 angle after mid-run reset", angle_o, 0);
    check(vel_o == 21'sd0, "R9 vel after mid-run reset", vel_o, 0);
    theta = 60000.0;
    ticks(2);
    rst_n = 1'b1;
    ticks(4);

    // R4: first step downward through the wrap
    stb_en = 1'b1;
    for (int i = 0; i < 2000 && angle_o == 16'd0; i++) @(negedge clk);
    check(angle_o == 16'd65535, "R4 first step down wraps", angle_o, 65535);

    // R2: static convergence around the whole circle
    for (int k = 0; k < 8; k++) begin
      theta = real'((60000 + 8192 * k) % 65536);
      ticks(14000);
      check(iabs(adiff(angle_o, theta)) <= TOL, "R2 static convergence",
            angle_o, rnd(theta));
    end

    // R5: constant forward rotation, 0.5 LSB per clock
    dtheta = 2.0;
    ticks(15000);
    check(iabs(adiff(angle_o, theta)) <= TOL, "R5 forward tracking", angle_o, rnd(theta));
    check((vel_o > 21'sd393216) && (vel_o < 21'sd655360), "R5 forward velocity", vel_o, 524288);

    // R5: constant reverse rotation
    dtheta = -2.0;
    ticks(15000);
    check(iabs(adiff(angle_o, theta)) <= TOL, "R5 reverse tracking", angle_o, rnd(theta));
    check((vel_o < -21'sd393216) && (vel_o > -21'sd655360), "R5 reverse velocity", vel_o, -524288);

    check(bad_steps == 0, "R3 single-LSB motion", bad_steps, 0);
    finish_run();
  end
endmodule